// File: doc/BRIEF.md
# Descriptor Ring Address Generator

This block turns the state of two circular descriptor rings, one for receive and one for transmit, into the byte addresses a DMA engine needs. Software-visible configuration (ring base pointers given as two 16-bit halves, ring lengths, the descriptor size selector, the pointer width mode and a 16-bit register whose upper byte extends short buffer pointers) is captured on a load strobe. Each ring keeps a counter that runs downward from the ring length. The slot a counter selects sits at `base + (length - counter) * stride`.

The receive side exposes three addresses at once: the current slot and the two slots after it, so that a prefetcher can look ahead. The transmit side exposes its current slot. A separate path widens a buffer pointer to a full physical address when short pointers are in use. The descriptor engine pulses an advance strobe whenever it consumes a slot. The counter then steps to the next slot, or reloads to the ring length once it reaches the last slot. All address outputs are combinational from the captured registers and counters.

Top module: `ring_addr_gen`

## Requirements
- R1: After reset both counters read 0, both ring-valid flags are low, and the current-slot addresses of both rings read 0.
- R2: On a cycle with `cfg_load` high, the base of each ring is captured as `{base_hi, base_lo}`, with the low half from the `_lo` port. From the following cycle each counter equals its new ring length.
- R3: The current slot address is `base + (length - counter) * 8` when `wide_desc` is 0.
- R4: With `wide_desc` at 1 the stride is 16 bytes instead of 8, for every slot address.
- R5: The receive look-ahead addresses use index `counter-1` and `counter-2`. Any index below 1 has the ring length added to it until it is at least 1, so a ring of length 1 gives the same address for all three slots.
- R6: An advance strobe on a ring whose counter is above 1 lowers that counter by exactly one, visible the next cycle.
- R7: An advance strobe on a ring whose counter is 1 or less reloads the counter with the ring length. The counter never exceeds the captured length.
- R8: When `cfg_load` and an advance strobe arrive in the same cycle, the load wins and the counter takes the new length.
- R9: A ring-valid flag is low exactly when that ring's captured base is zero.
- R10: With `ptr32_mode` at 0 the buffer address is the input OR'd with bits [15:8] of the captured extension register placed at bits [31:24]. The low byte of that register has no effect. With `ptr32_mode` at 1 the input passes through unchanged.
- R11: The two rings are independent: an advance on one never changes the other ring's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Capture configuration and reload both counters |
| rx_base_lo | input | 16 | Receive ring base, low half |
| rx_base_hi | input | 16 | Receive ring base, high half |
| tx_base_lo | input | 16 | Transmit ring base, low half |
| tx_base_hi | input | 16 | Transmit ring base, high half |
| rx_ring_len | input | 16 | Receive ring length in slots |
| tx_ring_len | input | 16 | Transmit ring length in slots |
| wide_desc | input | 1 | 1: 16-byte descriptors, 0: 8-byte descriptors |
| ptr32_mode | input | 1 | 1: buffer pointers are full width |
| ext_reg | input | 16 | Register whose upper byte extends short pointers |
| rx_adv | input | 1 | Receive slot consumed |
| tx_adv | input | 1 | Transmit slot consumed |
| buf_addr_in | input | 32 | Buffer pointer from a descriptor |
| rx_cur_addr | output | 32 | Current receive slot address |
| rx_nxt_addr | output | 32 | Next receive slot address |
| rx_nnx_addr | output | 32 | Receive slot address after the next one |
| tx_cur_addr | output | 32 | Current transmit slot address |
| rx_ring_ok | output | 1 | Receive base is nonzero |
| tx_ring_ok | output | 1 | Transmit base is nonzero |
| rx_count | output | 16 | Receive ring counter |
| tx_count | output | 16 | Transmit ring counter |
| buf_phys_addr | output | 32 | Widened buffer address |

## Verification
The hardest case to reach from the ports is the look-ahead wrap on a very short ring. Both look-ahead indices must fall below 1, and with a length of 1 the wrap needs more than one addition. The stimulus gets there by loading a length-1 ring while an advance strobe fires in the same cycle, and by stepping a length-5 ring down to counters 2 and 1. A scoreboard predicts every slot address by modular arithmetic rather than by repeated addition.

// File: rtl/ring_addr_pkg.sv
package ring_addr_pkg;
  localparam int unsigned RA_AW = 32;
  localparam int unsigned RA_CW = 16;
  localparam int unsigned RA_HW = 16;
  localparam int unsigned RA_IW = RA_CW + 2;
  localparam int unsigned STRIDE_LG_NARROW = 3;
  localparam int unsigned STRIDE_LG_WIDE = 4;
  localparam int unsigned WRAP_PASSES = 3;
  localparam int unsigned EXT_BYTE_SHIFT = 16;

  typedef logic [RA_AW-1:0] addr_t;
  typedef logic [RA_CW-1:0] cnt_t;
  typedef logic [RA_HW-1:0] half_t;
  typedef logic signed [RA_IW-1:0] idx_t;

  // Slot index counter-back; below 1 it wraps up by whole ring lengths.
  function automatic idx_t wrap_idx(cnt_t cnt, int unsigned back, cnt_t len);
    idx_t r;
    r = idx_t'({2'b00, cnt}) - idx_t'(back);
    for (int p = 0; p < WRAP_PASSES; p++) begin
      if (r < idx_t'(1) && len != '0) r = r + idx_t'({2'b00, len});
    end
    return r;
  endfunction

  function automatic addr_t slot_addr(addr_t base, cnt_t len, idx_t idx, logic wide);
    idx_t d;
    addr_t off;
    d = idx_t'({2'b00, len}) - idx;
    off = {{(RA_AW-RA_IW){d[RA_IW-1]}}, d};
    off = wide ? (off << STRIDE_LG_WIDE) : (off << STRIDE_LG_NARROW);
    return base + off;
  endfunction

  function automatic cnt_t step_count(cnt_t cnt, cnt_t len);
    return (cnt <= cnt_t'(1)) ? len : cnt - cnt_t'(1);
  endfunction

  function automatic addr_t widen_ptr(addr_t a, logic p32, half_t ext);
    addr_t hi;
    hi = addr_t'(ext & {8'hff, {(RA_HW-8){1'b0}}}) << EXT_BYTE_SHIFT;
    return p32 ? a : (a | hi);
  endfunction
endpackage

// File: rtl/ring_cnt.sv
module ring_cnt
  import ring_addr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cnt_t load_len,
  input  logic adv,
  output cnt_t cnt,
  output cnt_t len
);
  cnt_t cnt_q, len_q;
  logic step_ev, wrap_ev;

  assign step_ev = adv && !load && (cnt_q > cnt_t'(1));
  assign wrap_ev = adv && !load && (cnt_q <= cnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (load) begin
      cnt_q <= load_len;
      len_q <= load_len;
    end else if (adv) begin
      cnt_q <= step_count(cnt_q, len_q);
    end
  end

  assign cnt = cnt_q;
  assign len = len_q;

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> cnt_q == $past(cnt_q) - cnt_t'(1));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> cnt_q == $past(len_q));
  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len_q);
  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_len));
endmodule

// File: rtl/desc_addr_calc.sv
module desc_addr_calc
  import ring_addr_pkg::*;
#(
  parameter int unsigned N_SLOTS = 3
)(
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t base,
  input  cnt_t  len,
  input  cnt_t  cnt,
  input  logic  wide,
  output addr_t slot [N_SLOTS]
);
  addr_t ring_span;
  logic  cnt_in_ring;

  assign ring_span = wide ? (addr_t'(len) << STRIDE_LG_WIDE) : (addr_t'(len) << STRIDE_LG_NARROW);
  assign cnt_in_ring = (cnt >= cnt_t'(1)) && (cnt <= len);

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    assign slot[g] = slot_addr(base, len, wrap_idx(cnt, g, len), wide);

    p_in_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_in_ring |-> (slot[g] - base) < ring_span);
  end
endmodule

// File: rtl/buf_addr_ext.sv
module buf_addr_ext
  import ring_addr_pkg::*;
(
  input  addr_t a_in,
  input  logic  p32,
  input  half_t ext,
  output addr_t a_out
);
  assign a_out = widen_ptr(a_in, p32, ext);
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
  import ring_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [15:0] rx_base_lo,
  input  logic [15:0] rx_base_hi,
  input  logic [15:0] tx_base_lo,
  input  logic [15:0] tx_base_hi,
  input  logic [15:0] rx_ring_len,
  input  logic [15:0] tx_ring_len,
  input  logic        wide_desc,
  input  logic        ptr32_mode,
  input  logic [15:0] ext_reg,
  input  logic        rx_adv,
  input  logic        tx_adv,
  input  logic [31:0] buf_addr_in,
  output logic [31:0] rx_cur_addr,
  output logic [31:0] rx_nxt_addr,
  output logic [31:0] rx_nnx_addr,
  output logic [31:0] tx_cur_addr,
  output logic        rx_ring_ok,
  output logic        tx_ring_ok,
  output logic [15:0] rx_count,
  output logic [15:0] tx_count,
  output logic [31:0] buf_phys_addr
);
  localparam int unsigned N_RINGS = 2;
  localparam int unsigned RX = 0;
  localparam int unsigned TX = 1;
  localparam int unsigned RX_LOOK = 3;
  localparam int unsigned TX_LOOK = 1;

  addr_t rx_base_q, tx_base_q;
  logic  wide_q, p32_q;
  half_t ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_base_q <= '0;
      tx_base_q <= '0;
      wide_q    <= 1'b0;
      p32_q     <= 1'b0;
      ext_q     <= '0;
    end else if (cfg_load) begin
      rx_base_q <= {rx_base_hi, rx_base_lo};
      tx_base_q <= {tx_base_hi, tx_base_lo};
      wide_q    <= wide_desc;
      p32_q     <= ptr32_mode;
      ext_q     <= ext_reg;
    end
  end

  logic adv_v [N_RINGS];
  cnt_t new_len [N_RINGS];
  cnt_t cnt_v [N_RINGS];
  cnt_t len_v [N_RINGS];

  assign adv_v[RX]   = rx_adv;
  assign adv_v[TX]   = tx_adv;
  assign new_len[RX] = rx_ring_len;
  assign new_len[TX] = tx_ring_len;

  for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
    ring_cnt u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_load),
      .load_len (new_len[r]),
      .adv      (adv_v[r]),
      .cnt      (cnt_v[r]),
      .len      (len_v[r])
    );
  end

  addr_t rx_slot [RX_LOOK];
  addr_t tx_slot [TX_LOOK];

  desc_addr_calc #(.N_SLOTS(RX_LOOK)) u_rx_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .base  (rx_base_q),
    .len   (len_v[RX]),
    .cnt   (cnt_v[RX]),
    .wide  (wide_q),
    .slot  (rx_slot)
  );

  desc_addr_calc #(.N_SLOTS(TX_LOOK)) u_tx_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .base  (tx_base_q),
    .len   (len_v[TX]),
    .cnt   (cnt_v[TX]),
    .wide  (wide_q),
    .slot  (tx_slot)
  );

  buf_addr_ext u_buf (
    .a_in  (buf_addr_in),
    .p32   (p32_q),
    .ext   (ext_q),
    .a_out (buf_phys_addr)
  );

  assign rx_cur_addr = rx_slot[0];
  assign rx_nxt_addr = rx_slot[1];
  assign rx_nnx_addr = rx_slot[2];
  assign tx_cur_addr = tx_slot[0];
  assign rx_ring_ok  = rx_base_q != '0;
  assign tx_ring_ok  = tx_base_q != '0;
  assign rx_count    = cnt_v[RX];
  assign tx_count    = cnt_v[TX];

  p_tx_indep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_adv && !cfg_load) |=> $stable(tx_count));
  p_rx_indep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_adv && !cfg_load) |=> $stable(rx_count));
endmodule

// File: tb/ring_addr_gen_tb_top.sv
`timescale 1ns/1ps
module ring_addr_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_load = 0, wide_desc = 0, ptr32_mode = 0, rx_adv = 0, tx_adv = 0;
  logic [15:0] rx_base_lo = 0, rx_base_hi = 0, tx_base_lo = 0, tx_base_hi = 0;
  logic [15:0] rx_ring_len = 0, tx_ring_len = 0, ext_reg = 0;
  logic [31:0] buf_addr_in = 0;
  logic [31:0] rx_cur_addr, rx_nxt_addr, rx_nnx_addr, tx_cur_addr, buf_phys_addr;
  logic        rx_ring_ok, tx_ring_ok;
  logic [15:0] rx_count, tx_count;

  ring_addr_gen dut_i (.*);

  typedef struct {
    string       req;
    bit          full;
    logic [31:0] rc, rn, rnn, tc, bp;
    logic [15:0] rcnt, tcnt;
    logic        rok, tok;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int errors = 0, checks = 0;

  // reference model state
  logic [31:0] m_rxb = 0, m_txb = 0;
  int m_rxl = 0, m_txl = 0, m_rxc = 0, m_txc = 0;
  bit m_wide = 0, m_p32 = 0;
  logic [15:0] m_ext = 0;

  function automatic logic [31:0] ref_slot(logic [31:0] b, int l, int c, int k, bit w);
    int i;
    i = ((c - k - 1) % l + l) % l + 1;
    return b + 32'((l - i) * (w ? 16 : 8));
  endfunction

  function automatic exp_t predict(string req, bit full);
    exp_t e;
    e.req = req; e.full = full;
    e.rcnt = 16'(m_rxc); e.tcnt = 16'(m_txc);
    e.rok = (m_rxb != 0); e.tok = (m_txb != 0);
    e.bp = m_p32 ? buf_addr_in : (buf_addr_in | {m_ext[15:8], 24'h0});
    if (full) begin
      e.rc  = ref_slot(m_rxb, m_rxl, m_rxc, 0, m_wide);
      e.rn  = ref_slot(m_rxb, m_rxl, m_rxc, 1, m_wide);
      e.rnn = ref_slot(m_rxb, m_rxl, m_rxc, 2, m_wide);
      e.tc  = ref_slot(m_txb, m_txl, m_txc, 0, m_wide);
    end else begin
      e.rc = 0; e.rn = 0; e.rnn = 0; e.tc = 0;
    end
    return e;
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops predictions and compares against the ports
  initial begin
    exp_t e;
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        e = q.pop_front();
        cmp(e.req, "rx_count", 32'(rx_count), 32'(e.rcnt));
        cmp(e.req, "tx_count", 32'(tx_count), 32'(e.tcnt));
        cmp(e.req, "rx_ring_ok", 32'(rx_ring_ok), 32'(e.rok));
        cmp(e.req, "tx_ring_ok", 32'(tx_ring_ok), 32'(e.tok));
        cmp(e.req, "buf_phys_addr", buf_phys_addr, e.bp);
        cmp(e.req, "rx_cur_addr", rx_cur_addr, e.rc);
        cmp(e.req, "tx_cur_addr", tx_cur_addr, e.tc);
        if (e.full) begin
          cmp(e.req, "rx_nxt_addr", rx_nxt_addr, e.rn);
          cmp(e.req, "rx_nnx_addr", rx_nnx_addr, e.rnn);
        end
      end
    end
  end

  task automatic push(string req, bit full = 1);
    q.push_back(predict(req, full));
    #0 -> chk_ev;
    #1;
  endtask

  task automatic do_cfg(string req, logic [31:0] rb, logic [31:0] tb, int rl, int tl,
                        bit w, bit p32, logic [15:0] ext, bit radv = 0);
    @(negedge clk);
    {rx_base_hi, rx_base_lo} = rb; {tx_base_hi, tx_base_lo} = tb;
    rx_ring_len = 16'(rl); tx_ring_len = 16'(tl);
    wide_desc = w; ptr32_mode = p32; ext_reg = ext;
    cfg_load = 1; rx_adv = radv;
    @(negedge clk);
    cfg_load = 0; rx_adv = 0;
    m_rxb = rb; m_txb = tb; m_rxl = rl; m_txl = tl; m_rxc = rl; m_txc = tl;
    m_wide = w; m_p32 = p32; m_ext = ext;
    push(req);
  endtask

  task automatic do_adv(string req, bit ra, bit ta);
    @(negedge clk);
    rx_adv = ra; tx_adv = ta;
    @(negedge clk);
    rx_adv = 0; tx_adv = 0;
    if (ra) m_rxc = (m_rxc <= 1) ? m_rxl : m_rxc - 1;
    if (ta) m_txc = (m_txc <= 1) ? m_txl : m_txc - 1;
    push(req);
  endtask

  task automatic do_buf(string req, logic [31:0] a);
    @(negedge clk);
    buf_addr_in = a;
    #1;
    push(req);
  endtask

  bit wd_hit = 0;
  initial begin
    #200000;
    wd_hit = 1;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    push("R1 reset", 0);
    rst_n = 1;
    @(negedge clk);
    push("R1 after release", 0);

    // R2 R3 R9: halves assembled, counters loaded, stride 8
    do_cfg("R2 R3 R9 load", 32'h0012_3400, 32'h0040_0000, 5, 3, 0, 1, 16'h0000);
    // R6 R5: step down, look-ahead wraps at counters 2 and 1
    do_adv("R6 rx 5->4", 1, 0);
    do_adv("R6 R5 rx 4->3", 1, 0);
    do_adv("R5 rx 3->2 nnx wraps", 1, 0);
    do_adv("R5 rx 2->1 nxt wraps", 1, 0);
    // R7: reload from 1
    do_adv("R7 rx 1->5", 1, 0);
    // R11: tx only, rx untouched
    do_adv("R11 tx 3->2", 0, 1);
    do_adv("R11 tx 2->1", 0, 1);
    do_adv("R7 R11 tx 1->3", 0, 1);
    do_adv("R6 R11 both", 1, 1);
    // R8 R4 R5: load wins over advance; len 1 wraps the look-ahead twice
    do_cfg("R8 R4 R5 load vs adv len1", 32'h8000_0100, 32'h0000_2000, 1, 4, 1, 1, 16'h0000, 1);
    do_adv("R7 R4 len1 reload", 1, 0);
    do_adv("R4 tx wide step", 0, 1);
    // R9: zero tx base; R10 short pointers
    do_cfg("R9 R10 zero base", 32'h0000_0040, 32'h0000_0000, 7, 2, 0, 0, 16'hAB5C);
    do_buf("R10 widen", 32'h0000_1234);
    do_buf("R10 widen keeps low bits", 32'h00FF_FFF0);
    do_cfg("R10 ptr32 pass", 32'h0000_0040, 32'h0000_0100, 7, 2, 0, 1, 16'hAB5C);
    do_buf("R10 pass", 32'h0011_2233);
    do_adv("R6 R3 rx 7->6", 1, 0);

    repeat (2) @(negedge clk);
    if (!wd_hit) begin
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule